// File: doc/BRIEF.md
# Sequential-Mode DMA Channel Engine

This block is a single DMA channel that moves data in sequential fashion between a stepping memory address and a fixed I/O address. Software programs a 24-bit memory address, a 16-bit I/O address, a 16-bit transfer count and a control word. Each external request then moves one byte or one word. The engine runs a read bus cycle from the source, holds the returned data in a register, and then runs a write bus cycle to the destination.

The I/O side address is the programmed 16-bit value with its upper 8 bits forced to all ones, and it never moves. The memory address steps up or down by the transfer size after every completed transfer. A direction bit chooses which of the two addresses is the source. When the count reaches zero, the channel disables itself, sets a sticky done flag and, if enabled, raises an interrupt until software clears the flag. Sequential operation requires the repeat-enable bit to be 0. With that bit set, the channel accepts no request.

Top module: `seqdma_chan`

## Requirements
- R1: After reset, no bus cycle is driven, the memory address, count and enable read back as 0, and done and irq are 0.
- R2: A configuration write with `cfg_sel` 0 loads the memory address (24 bits), 1 loads the I/O address (low 16 bits), 2 loads the count (low 16 bits) and 3 loads the control word. The control fields are bit0 enable, bit1 direction, bit2 word size, bit3 decrement, bit4 repeat-enable and bit5 interrupt enable. Writing bit6 as 1 clears done.
- R3: In idle, a request starts a transfer only when enable is 1, repeat-enable is 0 and the count is nonzero. Otherwise the request is ignored and no bus cycle starts. An accepted request drives a read cycle from the next cycle on.
- R4: With direction 0, the read address is the memory address and the write address is the I/O address. With direction 1, the two are swapped.
- R5: A bus cycle holds its address and kind until `bus_ready` is 1. The read data is captured at that edge, and the following write cycle drives it on `bus_wdata`. A byte transfer keeps bits 7:0 and drives the upper bits as zero, and `bus_word` shows the size.
- R6: When the write completes, the memory address steps by 1 for a byte or 2 for a word, upward when decrement is 0 and downward when it is 1, wrapping modulo 2^24.
- R7: Each completed transfer lowers the count by one. The transfer that brings it to 0 also clears enable.
- R8: The transfer that brings the count to 0 sets done, and done stays set until a control write with bit6 = 1. irq equals done AND interrupt enable.
- R9: Requests during a transfer are ignored. A new request is taken only in a cycle after the write has completed, so a request held high yields exactly one transfer per count.
- R10: The I/O side address on the bus is always 0xFF in bits 23:16 over the programmed 16 bits, whatever the transfers do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 24 | Configuration write data |
| xfer_req | input | 1 | Transfer request |
| bus_valid | output | 1 | Bus cycle active |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = word, 0 = byte |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Bus cycle completes at this edge |
| cur_maddr | output | 24 | Current memory address |
| cur_count | output | 16 | Current transfer count |
| chan_en | output | 1 | Channel enable state |
| done | output | 1 | Sticky run-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software writes no configuration while a transfer is in flight, so the direction, size and addresses stay still during a bus cycle. They also assume that `bus_ready` is meaningful only while `bus_valid` is high. The stimulus programs every register only while the engine is idle. It drives `bus_ready` with a repeating pattern that includes stall cycles, and it holds or pulses requests in ways that probe acceptance while disabled, while in repeat mode, with a zero count and during an active transfer.

// File: rtl/seqdma_pkg.sv
package seqdma_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_MADDR = 2'd0;
    localparam logic [1:0] SEL_IOADDR = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int CB_EN = 0;
    localparam int CB_DIR = 1;
    localparam int CB_WORD = 2;
    localparam int CB_DEC = 3;
    localparam int CB_RPT = 4;
    localparam int CB_IRQEN = 5;
    localparam int CB_DCLR = 6;
endpackage

// File: rtl/seqdma_regs.sv
module seqdma_regs
    import seqdma_pkg::*;
#(
    parameter int AW = 24,
    parameter int IOW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          step_i,
    input  logic [AW-1:0] next_maddr_i,
    output logic [AW-1:0] maddr_o,
    output logic [IOW-1:0] ioaddr_o,
    output logic [CW-1:0] count_o,
    output logic          en_o,
    output logic          dir_o,
    output logic          word_o,
    output logic          dec_o,
    output logic          rpt_o,
    output logic          irqen_o,
    output logic          done_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [AW-1:0]  maddr;
        logic [IOW-1:0] ioaddr;
        logic [CW-1:0]  count;
        logic en;
        logic dir;
        logic word;
        logic dec;
        logic rpt;
        logic irqen;
        logic done;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_MADDR:  d.maddr = cfg_wdata;
                SEL_IOADDR: d.ioaddr = cfg_wdata[IOW-1:0];
                SEL_COUNT:  d.count = cfg_wdata[CW-1:0];
                default: begin
                    d.en    = cfg_wdata[CB_EN];
                    d.dir   = cfg_wdata[CB_DIR];
                    d.word  = cfg_wdata[CB_WORD];
                    d.dec   = cfg_wdata[CB_DEC];
                    d.rpt   = cfg_wdata[CB_RPT];
                    d.irqen = cfg_wdata[CB_IRQEN];
                    if (cfg_wdata[CB_DCLR]) d.done = 1'b0;
                end
            endcase
        end
        if (step_i) begin
            d.maddr = next_maddr_i;
            d.count = q.count - ONE;
            if (q.count == ONE) begin
                d.en   = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign maddr_o  = q.maddr;
    assign ioaddr_o = q.ioaddr;
    assign count_o  = q.count;
    assign en_o     = q.en;
    assign dir_o    = q.dir;
    assign word_o   = q.word;
    assign dec_o    = q.dec;
    assign rpt_o    = q.rpt;
    assign irqen_o  = q.irqen;
    assign done_o   = q.done;

    assert_step_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (q.count == $past(q.count) - ONE));

    assert_done_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> !q.en);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !(cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[CB_DCLR])) |=> q.done);
endmodule

// File: rtl/seqdma_addr.sv
module seqdma_addr #(
    parameter int AW = 24,
    parameter int IOW = 16
) (
    input  logic [AW-1:0]  maddr_i,
    input  logic [IOW-1:0] ioaddr_i,
    input  logic           dir_i,
    input  logic           word_i,
    input  logic           dec_i,
    output logic [AW-1:0]  src_o,
    output logic [AW-1:0]  dst_o,
    output logic [AW-1:0]  next_maddr_o
);
    localparam int PADW = AW - IOW;

    logic [AW-1:0] io_full;
    logic [AW-1:0] stride;

    always_comb begin
        io_full = {{PADW{1'b1}}, ioaddr_i};
        stride  = word_i ? AW'(2) : AW'(1);
        if (dir_i) begin
            src_o = io_full;
            dst_o = maddr_i;
        end else begin
            src_o = maddr_i;
            dst_o = io_full;
        end
        next_maddr_o = dec_i ? (maddr_i - stride) : (maddr_i + stride);
    end
endmodule

// File: rtl/seqdma_seq.sv
module seqdma_seq
    import seqdma_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          start_ok_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          word_i,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_valid,
    output logic          bus_write,
    output logic          bus_word,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          step_o
);
    localparam int BW = DW / 2;

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] hold;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        step_o = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (req_i && start_ok_i) d.ph = PH_READ;
            end
            PH_READ: begin
                if (bus_ready) begin
                    d.hold = word_i ? bus_rdata : {{(DW-BW){1'b0}}, bus_rdata[BW-1:0]};
                    d.ph   = PH_WRITE;
                end
            end
            PH_WRITE: begin
                if (bus_ready) begin
                    d.ph   = PH_IDLE;
                    step_o = 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{ph: PH_IDLE, hold: '0};
        else        q <= d;
    end

    assign bus_valid = (q.ph != PH_IDLE);
    assign bus_write = (q.ph == PH_WRITE);
    assign bus_word  = word_i;
    assign bus_addr  = (q.ph == PH_WRITE) ? dst_i : src_i;
    assign bus_wdata = (q.ph == PH_WRITE) ? q.hold : '0;

    assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_ready) |=> (bus_valid && bus_write));

    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));

    assert_idle_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_ready) |=> !bus_valid);
endmodule

// File: rtl/seqdma_chan.sv
module seqdma_chan
    import seqdma_pkg::*;
#(
    parameter int AW = 24,
    parameter int IOW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          xfer_req,
    output logic          bus_valid,
    output logic          bus_write,
    output logic          bus_word,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic [AW-1:0] cur_maddr,
    output logic [CW-1:0] cur_count,
    output logic          chan_en,
    output logic          done,
    output logic          irq
);
    logic [AW-1:0]  maddr, next_maddr, src, dst;
    logic [IOW-1:0] ioaddr;
    logic [CW-1:0]  count;
    logic en, dir, word, dec, rpt, irqen, step, start_ok;

    seqdma_regs #(.AW(AW), .IOW(IOW), .CW(CW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .step_i(step), .next_maddr_i(next_maddr),
        .maddr_o(maddr), .ioaddr_o(ioaddr), .count_o(count),
        .en_o(en), .dir_o(dir), .word_o(word), .dec_o(dec),
        .rpt_o(rpt), .irqen_o(irqen), .done_o(done)
    );

    seqdma_addr #(.AW(AW), .IOW(IOW)) addr_i (
        .maddr_i(maddr), .ioaddr_i(ioaddr), .dir_i(dir), .word_i(word), .dec_i(dec),
        .src_o(src), .dst_o(dst), .next_maddr_o(next_maddr)
    );

    assign start_ok = en && !rpt && (count != '0);

    seqdma_seq #(.AW(AW), .DW(DW)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_i(xfer_req), .start_ok_i(start_ok),
        .src_i(src), .dst_i(dst), .word_i(word),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .step_o(step)
    );

    assign cur_maddr = maddr;
    assign cur_count = count;
    assign chan_en   = en;
    assign irq       = done & irqen;

    localparam int PADW = AW - IOW;

    assert_io_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_write != dir)) |-> (bus_addr[AW-1:IOW] == {PADW{1'b1}}));

    assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !en) |=> !bus_valid);
endmodule

// File: tb/seqdma_chan_tb.sv
module seqdma_chan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [23:0] cfg_wdata = '0;
    logic xfer_req = 1'b0;
    logic bus_valid, bus_write, bus_word, chan_en, done, irq;
    logic [23:0] bus_addr, cur_maddr;
    logic [15:0] bus_wdata, bus_rdata, cur_count;
    logic bus_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqdma_chan dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .xfer_req(xfer_req), .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .cur_maddr(cur_maddr), .cur_count(cur_count), .chan_en(chan_en), .done(done), .irq(irq)
    );

    function automatic logic [15:0] mem_fn(input logic [23:0] a);
        return a[15:0] ^ 16'hA5C3 ^ {a[23:16], 8'h00};
    endfunction

    assign bus_rdata = mem_fn(bus_addr);

    // reference model state
    int m_ph = 0;
    logic [23:0] m_maddr = '0;
    logic [15:0] m_io = '0, m_cnt = '0, m_hold = '0;
    logic m_en = 0, m_dir = 0, m_word = 0, m_dec = 0, m_rpt = 0, m_irqen = 0, m_done = 0;
    int m_xfers = 0;

    function automatic logic [23:0] m_src();
        return m_dir ? {8'hFF, m_io} : m_maddr;
    endfunction
    function automatic logic [23:0] m_dst();
        return m_dir ? m_maddr : {8'hFF, m_io};
    endfunction

    always @(posedge clk) begin
        logic step;
        logic [23:0] o_maddr;
        logic [15:0] o_cnt;
        logic o_word, o_dec;
        step = 1'b0;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_maddr = '0; m_io = '0; m_cnt = '0; m_hold = '0;
            m_en = 0; m_dir = 0; m_word = 0; m_dec = 0; m_rpt = 0; m_irqen = 0; m_done = 0;
        end else begin
            o_maddr = m_maddr; o_cnt = m_cnt; o_word = m_word; o_dec = m_dec;
            case (m_ph)
                0: if (xfer_req && m_en && !m_rpt && m_cnt != 0) m_ph = 1;
                1: if (bus_ready) begin
                       m_hold = m_word ? mem_fn(m_src()) : {8'h00, mem_fn(m_src())[7:0]};
                       m_ph = 2;
                   end
                default: if (bus_ready) begin m_ph = 0; step = 1'b1; end
            endcase
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_maddr = cfg_wdata;
                    2'd1: m_io = cfg_wdata[15:0];
                    2'd2: m_cnt = cfg_wdata[15:0];
                    default: begin
                        m_en = cfg_wdata[0]; m_dir = cfg_wdata[1]; m_word = cfg_wdata[2];
                        m_dec = cfg_wdata[3]; m_rpt = cfg_wdata[4]; m_irqen = cfg_wdata[5];
                        if (cfg_wdata[6]) m_done = 0;
                    end
                endcase
            end
            if (step) begin
                m_xfers++;
                if (o_dec) m_maddr = o_maddr - (o_word ? 24'd2 : 24'd1);
                else       m_maddr = o_maddr + (o_word ? 24'd2 : 24'd1);
                m_cnt = o_cnt - 16'd1;
                if (o_cnt == 16'd1) begin m_en = 0; m_done = 1; end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 bus_valid", 32'(bus_valid), 32'(m_ph != 0));
            chk("R4 bus_write", 32'(bus_write), 32'(m_ph == 2));
            if (m_ph != 0) begin
                if ((m_ph == 2) != m_dir)
                    chk("R10 io address", 32'(bus_addr), 32'(m_ph == 2 ? m_dst() : m_src()));
                else
                    chk("R4 mem address", 32'(bus_addr), 32'(m_ph == 2 ? m_dst() : m_src()));
                chk("R5 bus_word", 32'(bus_word), 32'(m_word));
            end
            if (m_ph == 2) chk("R5 write data", 32'(bus_wdata), 32'(m_hold));
            chk("R6 cur_maddr", 32'(cur_maddr), 32'(m_maddr));
            chk("R7 cur_count", 32'(cur_count), 32'(m_cnt));
            chk("R7 chan_en", 32'(chan_en), 32'(m_en));
            chk("R8 done", 32'(done), 32'(m_done));
            chk("R8 irq", 32'(irq), 32'(m_done & m_irqen));
        end
    end

    // bus ready pattern with stalls
    always @(negedge clk) bus_ready = ((cyc % 5) != 1) && ((cyc % 7) != 3);

    // watchdog
    always @(posedge clk) begin
        if (cyc > WDOG) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=<%0d", cyc, WDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cfg(input logic [1:0] sel, input logic [23:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!bus_valid && m_ph == 0) break;
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int start_x;
        idle_cycles(3);
        // R1: reset state
        chk("R1 bus_valid", 32'(bus_valid), 0);
        chk("R1 cur_maddr", 32'(cur_maddr), 0);
        chk("R1 cur_count", 32'(cur_count), 0);
        chk("R1 chan_en", 32'(chan_en), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 irq", 32'(irq), 0);
        rst_n = 1'b1;

        // R3: request while disabled is ignored
        pulse_req();
        idle_cycles(2);
        chk("R3 disabled request ignored", 32'(bus_valid), 0);

        // R2: program byte, increment, dir 0, irq enable, 3 transfers
        cfg(2'd0, 24'h001000);
        cfg(2'd1, 24'h000040);
        cfg(2'd2, 24'h000003);
        cfg(2'd3, 24'h000021);
        chk("R2 maddr load", 32'(cur_maddr), 32'h001000);
        chk("R2 count load", 32'(cur_count), 3);
        chk("R2 enable load", 32'(chan_en), 1);

        // R3: accepted request drives a read from the next cycle
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        chk("R3 read starts", 32'({bus_valid, bus_write}), 32'b10);
        chk("R4 read from memory", 32'(bus_addr), 32'h001000);
        wait_idle();
        pulse_req(); wait_idle();
        pulse_req(); wait_idle();
        chk("R6 byte increment", 32'(cur_maddr), 32'h001003);
        chk("R7 count zero", 32'(cur_count), 0);
        chk("R7 enable cleared", 32'(chan_en), 0);
        chk("R8 done set", 32'(done), 1);
        chk("R8 irq raised", 32'(irq), 1);

        // R8: done sticky over other writes, cleared by bit6
        cfg(2'd2, 24'h000002);
        chk("R8 done sticky", 32'(done), 1);
        cfg(2'd3, 24'h000040);
        chk("R8 done cleared", 32'(done), 0);
        chk("R8 irq cleared", 32'(irq), 0);

        // R3: repeat-enable set blocks requests
        cfg(2'd3, 24'h000011);
        pulse_req();
        idle_cycles(2);
        chk("R3 repeat mode ignores request", 32'(bus_valid), 0);
        chk("R3 count untouched", 32'(cur_count), 2);

        // R3: zero count blocks requests
        cfg(2'd2, 24'h000000);
        cfg(2'd3, 24'h000001);
        pulse_req();
        idle_cycles(2);
        chk("R3 zero count ignores request", 32'(bus_valid), 0);

        // R4/R6: dir 1, word, decrement, wrap below zero
        cfg(2'd0, 24'h000002);
        cfg(2'd1, 24'h00BEEE);
        cfg(2'd2, 24'h000002);
        cfg(2'd3, 24'h00000F);
        pulse_req();
        chk("R4 dir1 read from io", 32'(bus_addr), 32'hFFBEEE);
        wait_idle();
        chk("R6 word decrement", 32'(cur_maddr), 32'h000000);
        pulse_req(); wait_idle();
        chk("R6 wrap modulo 2^24", 32'(cur_maddr), 32'hFFFFFE);
        chk("R8 done without irq enable", 32'({done, irq}), 32'b10);
        cfg(2'd3, 24'h000040);

        // R9: request held high through a run of 4 word transfers
        start_x = m_xfers;
        cfg(2'd0, 24'h123456);
        cfg(2'd1, 24'h000010);
        cfg(2'd2, 24'h000004);
        cfg(2'd3, 24'h000025);
        @(negedge clk);
        xfer_req = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!chan_en && !bus_valid) break;
        end
        xfer_req = 1'b0;
        idle_cycles(3);
        chk("R9 one transfer per count", 32'(m_xfers - start_x), 4);
        chk("R9 address after held request", 32'(cur_maddr), 32'h12345E);
        chk("R9 no transfer after end", 32'(bus_valid), 0);

        idle_cycles(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule